// File: doc/BRIEF.md
# ATA Device Task-File Register Interface

This block is the register face that an ATA device shows to the host. It decodes one command bank of eight registers and one control register. It keeps the addressing registers, the error byte and the device status. It also runs a single-sector programmed-I/O data port, backed by a sector buffer of one sector. On the far side, a simple word-at-a-time handshake lets the storage side fill the buffer for a host read and empty it after a host write.

Many register accesses are not passive. Each of the following produces its own action code, one cycle after the access: a status read, a data read, a data write, a drive/head write, a command write, and the assertion or release of soft reset. A read of alternate status returns the same byte as status and produces no action. When an interrupt is posted, the block also sets an interrupt flag in the neighbouring bus-master status register. The host interrupt line is masked by the interrupt-disable bit in device control.

Top module: `ata_taskfile_regs`

## Requirements
- R1: After reset, status reads 0x40 (only the ready bit 6), the error register reads 0x0001, the address registers read 0, and both `intrq` and `bm_int` are low.
- R2: In the command bank, offsets 2, 3, 4 and 5 are byte registers that read back what was written. A write to offset 1 (features) is discarded, so offset 1 still reads the error value.
- R3: A read of command offset 7 returns status and gives action code 1, and it clears a pending interrupt. A read of control offset 6 returns the same status byte, gives action 0 and leaves the interrupt in place.
- R4: Command offset 0 is a 16-bit data register. Outside a transfer it reads back the last word written. A write gives action 3 and a read gives action 2.
- R5: A write to offset 6 (drive/head) stores the byte and gives action 4. A write to offset 7 (command) gives action 5.
- R6: A control write with bit 2 set gives action 6 and enters soft reset: status reads 0x80 and any transfer is dropped. A later write with bit 2 clear, made while in reset, gives action 7 and restores status 0x40 and error 0x01. A write with bit 2 clear made outside reset gives action 0.
- R7: Control bit 1 (interrupt disable) is captured on every control write. `intrq` is high only while an interrupt is pending and that bit is clear.
- R8: Command 0x20 sets status to 0xC0 and raises `st_req` with `st_dir`=0. The storage side then delivers words 0..N-1 on successive `st_ack` cycles. After the last word, status reads 0x48 (DRQ is bit 3), offset 0 holds word 0, and an interrupt is posted.
- R9: During a sector read, each data read returns the current word and loads the next one. After N reads, DRQ clears and status reads 0x40.
- R10: Command 0x30 sets status 0x48. N data writes fill buffer words 0..N-1 in order. The block then shows status 0xC0 with `st_req`=1 and `st_dir`=1 and presents each word on `st_drain_data` at index `st_idx`. After the last acknowledge it posts an interrupt and returns to status 0x40.
- R11: Every posted interrupt sets `bm_int`, which stays set until `bm_int_clr` is pulsed.
- R12: Any other command opcode sets the error bit (status 0x41), loads error 0x04 and posts an interrupt. The next valid command clears the error bit and loads error 0x00.
- R13: An access to a control-bank offset other than 6 is an error. A write there changes nothing, a read returns 0x0000, and `acc_err` pulses one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel_ctl | input | 1 | 0 = command bank, 1 = control bank |
| reg_off | input | 3 | Register offset |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data (bytes use bits 7:0) |
| reg_rdata | output | 16 | Read data, valid while reg_rd is high |
| dev_action | output | 3 | Action code of the previous cycle's access |
| acc_err | output | 1 | Previous access hit an unassigned offset |
| intrq | output | 1 | Host interrupt request |
| bm_int | output | 1 | Interrupt flag of the bus-master status register |
| bm_int_clr | input | 1 | Clears bm_int |
| soft_rst | output | 1 | Device is held in soft reset |
| st_req | output | 1 | Storage transfer in progress |
| st_dir | output | 1 | 0 = fill buffer, 1 = drain buffer |
| st_idx | output | 8 | Buffer word index of the current storage transfer |
| st_ack | input | 1 | Storage side moves one word this cycle |
| st_fill_data | input | 16 | Word delivered by the storage side |
| st_drain_data | output | 16 | Word presented to the storage side |

## Verification
Sector reads are run with several randomly keyed fill patterns. Because every word of a sector differs, a wrong preload, an off-by-one reload or a skipped decrement all show up as a mismatch at a known word. A sector write with random data, drained and compared index by index, separates a correct buffer offset from a reversed or shifted one. Directed accesses to each register, to the soft-reset edges, to the interrupt-disable bit and to unassigned control offsets show whether each side effect belongs to the right access alone. One example is status read against alternate status read, which should differ only in the action code and in clearing the interrupt.

// File: rtl/ata_tf_pkg.sv
// Shared offsets, bit positions, opcodes and codes for the task-file interface.
package ata_tf_pkg;
    localparam logic [2:0] OFF_DATA    = 3'd0;
    localparam logic [2:0] OFF_ERRFEAT = 3'd1;
    localparam logic [2:0] OFF_DRVHD   = 3'd6;
    localparam logic [2:0] OFF_STATCMD = 3'd7;
    localparam logic [2:0] OFF_CTL     = 3'd6;
    localparam int         SRST_BIT    = 2;
    localparam int         NIEN_BIT    = 1;
    localparam logic [7:0] OP_RD_SECT  = 8'h20;
    localparam logic [7:0] OP_WR_SECT  = 8'h30;
    localparam logic [7:0] ERR_DIAG_OK = 8'h01;
    localparam logic [7:0] ERR_ABORT   = 8'h04;

    typedef enum logic [2:0] {
        ACT_NONE, ACT_STAT_RD, ACT_DATA_RD, ACT_DATA_WR,
        ACT_SELECT, ACT_CMD, ACT_SRST_SET, ACT_SRST_CLR
    } act_e;

    typedef enum logic [2:0] {
        PS_IDLE, PS_FILL, PS_HRD, PS_HWR, PS_DRAIN
    } pio_e;

    typedef struct packed {
        logic data_rd;
        logic data_wr;
        logic stat_rd;
        logic tf_wr;
        logic sel_wr;
        logic cmd_wr;
        logic ctl_wr;
        logic bad;
    } dec_t;
endpackage

// File: rtl/ata_tf_decode.sv
// Access decoder: turns bank select, offset and strobes into one-hot access
// strobes. Assumes at most one of read/write per cycle; write wins if both.
module ata_tf_decode
    import ata_tf_pkg::*;
(
    input  logic       sel_ctl,
    input  logic [2:0] off,
    input  logic       rd,
    input  logic       wr,
    output dec_t       dec
);
    logic rd_only;
    assign rd_only = rd & ~wr;

    // Classify the current access by bank and offset.
    always_comb begin
        dec = '0;
        if (sel_ctl) begin
            if (off == OFF_CTL) dec.ctl_wr = wr;
            else                dec.bad    = rd | wr;
        end else begin
            case (off)
                OFF_DATA:    begin dec.data_rd = rd_only; dec.data_wr = wr; end
                OFF_ERRFEAT: ;
                OFF_STATCMD: begin dec.stat_rd = rd_only; dec.cmd_wr = wr; end
                default:     begin
                    dec.tf_wr  = wr;
                    dec.sel_wr = wr && (off == OFF_DRVHD);
                end
            endcase
        end
    end
endmodule

// File: rtl/ata_tf_sector_buf.sv
// One-sector word buffer: one write port, one asynchronous read port.
// Assumes the caller never writes and needs the same word in one cycle.
module ata_tf_sector_buf #(
    parameter int WORDS = 256,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [15:0]      wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [15:0]      rdata
);
    logic [15:0] mem [WORDS];

    // Store one word per write strobe.
    always_ff @(posedge clk) begin
        if (we) mem[widx] <= wdata;
    end

    assign rdata = mem[ridx];
endmodule

// File: rtl/ata_tf_pio.sv
// PIO sequencer: runs sector read (fill then host reads) and sector write
// (host writes then drain). Owns the data register and the command error bit.
// Assumes WORDS >= 2; abort (soft reset) returns everything to idle.
module ata_tf_pio
    import ata_tf_pkg::*;
#(
    parameter int WORDS = 256,
    localparam int IDX_W = $clog2(WORDS),
    localparam int CNT_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             abort,
    input  logic             cmd_go,
    input  logic [7:0]       cmd_op,
    input  logic             data_rd,
    input  logic             data_wr,
    input  logic [15:0]      wdata,
    input  logic             st_ack,
    input  logic [15:0]      st_fill_data,
    input  logic [15:0]      buf_rdata,
    output logic             st_req,
    output logic             st_dir,
    output logic [IDX_W-1:0] st_idx,
    output logic             buf_we,
    output logic [IDX_W-1:0] buf_widx,
    output logic [15:0]      buf_wdata,
    output logic [IDX_W-1:0] buf_ridx,
    output logic [15:0]      data_q,
    output logic             bsy,
    output logic             drq,
    output logic             cmd_err,
    output logic             post_int
);
    pio_e             state;
    logic [CNT_W-1:0] left;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] host_pos;
    logic             last_idx;
    logic             known_op;

    assign host_pos = IDX_W'(CNT_W'(WORDS) - left);
    assign last_idx = (idx == IDX_W'(WORDS - 1));
    assign known_op = (cmd_op == OP_RD_SECT) || (cmd_op == OP_WR_SECT);
    assign st_req   = (state == PS_FILL) || (state == PS_DRAIN);
    assign st_dir   = (state == PS_DRAIN);
    assign st_idx   = idx;
    assign bsy      = st_req;
    assign drq      = (state == PS_HRD) || (state == PS_HWR);

    // Route the buffer ports from whichever side owns the transfer.
    always_comb begin
        buf_we    = ((state == PS_FILL) && st_ack) || ((state == PS_HWR) && data_wr);
        buf_widx  = (state == PS_FILL) ? idx : host_pos;
        buf_wdata = (state == PS_FILL) ? st_fill_data : wdata;
        case (state)
            PS_HRD:   buf_ridx = host_pos + IDX_W'(1);
            PS_DRAIN: buf_ridx = idx;
            default:  buf_ridx = '0;
        endcase
        post_int = !abort && (
                   (st_req && st_ack && last_idx) ||
                   (cmd_go && !known_op));
    end

    // Sequence the sector transfer and keep the data register.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            state   <= PS_IDLE;
            left    <= '0;
            idx     <= '0;
            data_q  <= '0;
            cmd_err <= 1'b0;
        end else if (cmd_go) begin
            cmd_err <= !known_op;
            idx     <= '0;
            left    <= CNT_W'(WORDS);
            if (cmd_op == OP_RD_SECT)      state <= PS_FILL;
            else if (cmd_op == OP_WR_SECT) state <= PS_HWR;
            else                           state <= PS_IDLE;
        end else begin
            if (data_wr) data_q <= wdata;
            case (state)
                PS_FILL: if (st_ack) begin
                    idx <= idx + IDX_W'(1);
                    if (last_idx) begin
                        state  <= PS_HRD;
                        left   <= CNT_W'(WORDS);
                        data_q <= buf_rdata;
                    end
                end
                PS_HRD: if (data_rd) begin
                    left <= left - CNT_W'(1);
                    if (left == CNT_W'(1)) state  <= PS_IDLE;
                    else                   data_q <= buf_rdata;
                end
                PS_HWR: if (data_wr) begin
                    left <= left - CNT_W'(1);
                    if (left == CNT_W'(1)) begin
                        state <= PS_DRAIN;
                        idx   <= '0;
                    end
                end
                PS_DRAIN: if (st_ack) begin
                    idx <= idx + IDX_W'(1);
                    if (last_idx) state <= PS_IDLE;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ata_taskfile_regs.sv
// Host-visible task-file register interface of an ATA device. Holds the
// address registers, error, interrupt disable, soft reset, pending interrupt
// and the bus-master interrupt flag, and reports each access's action code.
// Assumes one register access per cycle; read data is combinational.
module ata_taskfile_regs
    import ata_tf_pkg::*;
#(
    parameter int SECTOR_BYTES = 512,
    localparam int WORDS = SECTOR_BYTES / 2,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_sel_ctl,
    input  logic [2:0]       reg_off,
    input  logic             reg_rd,
    input  logic             reg_wr,
    input  logic [15:0]      reg_wdata,
    output logic [15:0]      reg_rdata,
    output logic [2:0]       dev_action,
    output logic             acc_err,
    output logic             intrq,
    output logic             bm_int,
    input  logic             bm_int_clr,
    output logic             soft_rst,
    output logic             st_req,
    output logic             st_dir,
    output logic [IDX_W-1:0] st_idx,
    input  logic             st_ack,
    input  logic [15:0]      st_fill_data,
    output logic [15:0]      st_drain_data
);
    dec_t             dec;
    logic [7:0]       seccnt_q, secnum_q, cyllo_q, cylhi_q, drvhd_q, err_q;
    logic             nien_q, srst_q, pend_q, bm_q, accerr_q;
    act_e             act_q;
    logic             srst_set, srst_clr;
    logic             buf_we, pio_bsy, pio_drq, pio_err, post_int;
    logic [IDX_W-1:0] buf_widx, buf_ridx;
    logic [15:0]      buf_wdata, buf_rdata, data_q;
    logic [7:0]       status;

    ata_tf_decode u_dec (
        .sel_ctl(reg_sel_ctl), .off(reg_off), .rd(reg_rd), .wr(reg_wr), .dec(dec)
    );

    ata_tf_sector_buf #(.WORDS(WORDS)) u_buf (
        .clk(clk), .we(buf_we), .widx(buf_widx), .wdata(buf_wdata),
        .ridx(buf_ridx), .rdata(buf_rdata)
    );

    ata_tf_pio #(.WORDS(WORDS)) u_pio (
        .clk(clk), .rst_n(rst_n), .abort(srst_q),
        .cmd_go(dec.cmd_wr), .cmd_op(reg_wdata[7:0]),
        .data_rd(dec.data_rd), .data_wr(dec.data_wr), .wdata(reg_wdata),
        .st_ack(st_ack), .st_fill_data(st_fill_data), .buf_rdata(buf_rdata),
        .st_req(st_req), .st_dir(st_dir), .st_idx(st_idx),
        .buf_we(buf_we), .buf_widx(buf_widx), .buf_wdata(buf_wdata),
        .buf_ridx(buf_ridx), .data_q(data_q), .bsy(pio_bsy), .drq(pio_drq),
        .cmd_err(pio_err), .post_int(post_int)
    );

    assign srst_set = dec.ctl_wr && reg_wdata[SRST_BIT];
    assign srst_clr = dec.ctl_wr && !reg_wdata[SRST_BIT] && srst_q;
    assign status   = {pio_bsy | srst_q, !srst_q, 2'b00, pio_drq, 2'b00, pio_err};

    // Store the address bytes written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seccnt_q <= '0; secnum_q <= '0; cyllo_q <= '0; cylhi_q <= '0; drvhd_q <= '0;
        end else if (dec.tf_wr) begin
            case (reg_off)
                3'd2:    seccnt_q <= reg_wdata[7:0];
                3'd3:    secnum_q <= reg_wdata[7:0];
                3'd4:    cyllo_q  <= reg_wdata[7:0];
                3'd5:    cylhi_q  <= reg_wdata[7:0];
                default: drvhd_q  <= reg_wdata[7:0];
            endcase
        end
    end

    // Track soft reset, interrupt disable and the error byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            srst_q <= 1'b0;
            nien_q <= 1'b0;
            err_q  <= ERR_DIAG_OK;
        end else begin
            if (dec.ctl_wr) nien_q <= reg_wdata[NIEN_BIT];
            if (srst_set)      srst_q <= 1'b1;
            else if (srst_clr) srst_q <= 1'b0;
            if (srst_clr)
                err_q <= ERR_DIAG_OK;
            else if (dec.cmd_wr && !srst_q)
                err_q <= ((reg_wdata[7:0] == OP_RD_SECT) || (reg_wdata[7:0] == OP_WR_SECT))
                         ? 8'h00 : ERR_ABORT;
        end
    end

    // Hold the pending interrupt and the bus-master flag; posting wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            bm_q   <= 1'b0;
        end else begin
            if (post_int) pend_q <= 1'b1;
            else if (dec.stat_rd || dec.cmd_wr || srst_set) pend_q <= 1'b0;
            if (post_int)        bm_q <= 1'b1;
            else if (bm_int_clr) bm_q <= 1'b0;
        end
    end

    // Report the action code and the bad-offset flag one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q    <= ACT_NONE;
            accerr_q <= 1'b0;
        end else begin
            accerr_q <= dec.bad;
            if (dec.stat_rd)      act_q <= ACT_STAT_RD;
            else if (dec.data_rd) act_q <= ACT_DATA_RD;
            else if (dec.data_wr) act_q <= ACT_DATA_WR;
            else if (dec.sel_wr)  act_q <= ACT_SELECT;
            else if (dec.cmd_wr)  act_q <= ACT_CMD;
            else if (srst_set)    act_q <= ACT_SRST_SET;
            else if (srst_clr)    act_q <= ACT_SRST_CLR;
            else                  act_q <= ACT_NONE;
        end
    end

    // Select the read value for the addressed register.
    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            if (reg_sel_ctl) begin
                if (reg_off == OFF_CTL) reg_rdata = {8'h00, status};
            end else begin
                case (reg_off)
                    3'd0: reg_rdata = data_q;
                    3'd1: reg_rdata = {8'h00, err_q};
                    3'd2: reg_rdata = {8'h00, seccnt_q};
                    3'd3: reg_rdata = {8'h00, secnum_q};
                    3'd4: reg_rdata = {8'h00, cyllo_q};
                    3'd5: reg_rdata = {8'h00, cylhi_q};
                    3'd6: reg_rdata = {8'h00, drvhd_q};
                    default: reg_rdata = {8'h00, status};
                endcase
            end
        end
    end

    assign dev_action    = act_q;
    assign acc_err       = accerr_q;
    assign intrq         = pend_q && !nien_q;
    assign bm_int        = bm_q;
    assign soft_rst      = srst_q;
    assign st_drain_data = buf_rdata;
endmodule

// File: rtl/ata_tf_checker.sv
// Property checker for the task-file interface, attached by bind.
module ata_tf_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_sel_ctl,
    input logic [2:0] reg_off,
    input logic       reg_rd,
    input logic       reg_wr,
    input logic [2:0] dev_action,
    input logic       acc_err,
    input logic       intrq,
    input logic       nien,
    input logic       pend,
    input logic       bm_int,
    input logic       soft_rst,
    input logic       st_req,
    input logic       drq
);
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        intrq |-> (pend && !nien)); // R7
    AST_ALT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !reg_wr && reg_sel_ctl) |=> (dev_action == 3'd0)); // R3
    AST_BAD_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        ((reg_rd || reg_wr) && reg_sel_ctl && reg_off != 3'd6) |=> acc_err); // R13
    AST_BM_ON_POST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> bm_int); // R11
    AST_SRST_NO_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst && $past(soft_rst)) |-> (!st_req && !drq)); // R6
    AST_BUSY_NOT_DRQ: assert property (@(posedge clk) disable iff (!rst_n)
        st_req |-> !drq); // R8
endmodule

bind ata_taskfile_regs ata_tf_checker u_chk (
    .clk(clk), .rst_n(rst_n), .reg_sel_ctl(reg_sel_ctl), .reg_off(reg_off),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .dev_action(dev_action), .acc_err(acc_err),
    .intrq(intrq), .nien(nien_q), .pend(pend_q), .bm_int(bm_int),
    .soft_rst(soft_rst), .st_req(st_req), .drq(pio_drq)
);

// File: tb/ata_taskfile_regs_test.sv
`timescale 1ns/1ps
module ata_taskfile_regs_test;
    localparam int WORDS = 256;

    logic        clk = 0, rst_n = 0;
    logic        reg_sel_ctl = 0, reg_rd = 0, reg_wr = 0, bm_int_clr = 0, st_ack = 0;
    logic [2:0]  reg_off = 0;
    logic [15:0] reg_wdata = 0, reg_rdata, st_fill_data, st_drain_data;
    logic [2:0]  dev_action;
    logic        acc_err, intrq, bm_int, soft_rst, st_req, st_dir;
    logic [7:0]  st_idx;
    logic [15:0] fill_key = 0;
    logic [15:0] wr_words [WORDS];
    int          total = 0, bad = 0;

    always #5 clk = ~clk;

    ata_taskfile_regs uut (.*);

    function automatic logic [15:0] pat(input logic [15:0] key, input int i);
        return (key ^ 16'(i * 40503)) + 16'(i);
    endfunction

    assign st_fill_data = pat(fill_key, int'(st_idx));

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic acc(input bit wr, input bit ctl, input logic [2:0] off,
                       input logic [15:0] wd, output logic [15:0] rd,
                       output logic [2:0] act, output logic err);
        @(negedge clk);
        reg_sel_ctl = ctl; reg_off = off; reg_wdata = wd;
        reg_wr = wr; reg_rd = !wr;
        #1 rd = reg_rdata;
        @(negedge clk);
        act = dev_action; err = acc_err;
        reg_wr = 0; reg_rd = 0;
    endtask

    task automatic clr_bm();
        @(negedge clk); bm_int_clr = 1;
        @(negedge clk); bm_int_clr = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: run did not finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] rd;
        logic [2:0]  act;
        logic        err;
        logic [7:0]  v;
        int          mism, n;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        acc(0, 1, 3'd6, 0, rd, act, err); chk("R1 status", rd, 16'h0040);
        acc(0, 0, 3'd1, 0, rd, act, err); chk("R1 error", rd, 16'h0001);
        acc(0, 0, 3'd2, 0, rd, act, err); chk("R1 seccnt", rd, 16'h0000);
        chk("R1 intrq", intrq, 0); chk("R1 bm_int", bm_int, 0);

        // R2 address registers, random values; features discarded
        for (int k = 0; k < 4; k++) begin
            for (int o = 2; o <= 5; o++) begin
                v = 8'($urandom);
                acc(1, 0, 3'(o), {8'h00, v}, rd, act, err);
                acc(0, 0, 3'(o), 0, rd, act, err);
                chk("R2 readback", rd, {8'h00, v});
            end
        end
        acc(1, 0, 3'd1, 16'h00AB, rd, act, err);
        acc(0, 0, 3'd1, 0, rd, act, err); chk("R2 features discarded", rd, 16'h0001);

        // R5 drive/head and command actions; R12 unknown opcode
        acc(1, 0, 3'd6, 16'h00E5, rd, act, err); chk("R5 select action", act, 4);
        acc(0, 0, 3'd6, 0, rd, act, err); chk("R5 drive readback", rd, 16'h00E5);
        acc(1, 0, 3'd7, 16'h0099, rd, act, err); chk("R5 command action", act, 5);
        acc(0, 0, 3'd1, 0, rd, act, err); chk("R12 abort error", rd, 16'h0004);
        chk("R12 intrq", intrq, 1); chk("R11 bm set", bm_int, 1);
        // R3 alternate status is silent, status read clears the interrupt
        acc(0, 1, 3'd6, 0, rd, act, err);
        chk("R3 alt value", rd, 16'h0041); chk("R3 alt action", act, 0);
        chk("R3 alt keeps irq", intrq, 1);
        acc(0, 0, 3'd7, 0, rd, act, err);
        chk("R3 status value", rd, 16'h0041); chk("R3 status action", act, 1);
        chk("R3 irq cleared", intrq, 0);
        chk("R11 bm sticky", bm_int, 1);
        clr_bm(); chk("R11 bm cleared", bm_int, 0);

        // R4 data register outside transfer
        acc(1, 0, 3'd0, 16'h1234, rd, act, err); chk("R4 write action", act, 3);
        acc(0, 0, 3'd0, 0, rd, act, err);
        chk("R4 readback", rd, 16'h1234); chk("R4 read action", act, 2);

        // R8/R9 sector reads with random patterns; R7 on the second
        for (int s = 0; s < 3; s++) begin
            fill_key = 16'($urandom);
            if (s == 1) acc(1, 1, 3'd6, 16'h0002, rd, act, err);
            acc(1, 0, 3'd7, 16'h0020, rd, act, err);
            acc(0, 1, 3'd6, 0, rd, act, err); chk("R8 busy status", rd, 16'h00C0);
            chk("R8 st_req", st_req, 1); chk("R8 st_dir", st_dir, 0);
            @(negedge clk); st_ack = 1;
            do @(negedge clk); while (st_req);
            st_ack = 0;
            acc(0, 1, 3'd6, 0, rd, act, err); chk("R8 drq status R12 clear", rd, 16'h0048);
            acc(0, 0, 3'd1, 0, rd, act, err); chk("R12 error cleared", rd, 16'h0000);
            chk("R11 bm after fill", bm_int, 1);
            if (s == 1) begin
                chk("R7 masked", intrq, 0);
                acc(1, 1, 3'd6, 16'h0000, rd, act, err);
                chk("R7 unmasked", intrq, 1); chk("R6 no release action", act, 0);
            end else chk("R8 intrq", intrq, 1);
            mism = 0;
            for (int i = 0; i < WORDS; i++) begin
                acc(0, 0, 3'd0, 0, rd, act, err);
                if (rd !== pat(fill_key, i)) mism++;
            end
            chk("R9 read words", mism, 0);
            acc(0, 1, 3'd6, 0, rd, act, err); chk("R9 drq clear", rd, 16'h0040);
            clr_bm();
        end

        // R10 sector write with random data
        for (int i = 0; i < WORDS; i++) wr_words[i] = 16'($urandom);
        acc(1, 0, 3'd7, 16'h0030, rd, act, err);
        acc(0, 1, 3'd6, 0, rd, act, err); chk("R10 drq status", rd, 16'h0048);
        for (int i = 0; i < WORDS; i++) acc(1, 0, 3'd0, wr_words[i], rd, act, err);
        acc(0, 1, 3'd6, 0, rd, act, err); chk("R10 busy status", rd, 16'h00C0);
        chk("R10 st_dir", st_dir, 1);
        mism = 0; n = 0;
        @(negedge clk); st_ack = 1;
        while (st_req) begin
            #1 if (st_drain_data !== wr_words[st_idx] || st_idx != 8'(n)) mism++;
            n++;
            @(negedge clk);
        end
        st_ack = 0;
        chk("R10 drain data", mism, 0); chk("R10 drain count", n, WORDS);
        acc(0, 1, 3'd6, 0, rd, act, err); chk("R10 done status", rd, 16'h0040);
        chk("R10 intrq", intrq, 1); chk("R11 bm after drain", bm_int, 1);

        // R6 soft reset during a transfer
        fill_key = 16'($urandom);
        acc(1, 0, 3'd7, 16'h0020, rd, act, err);
        acc(1, 1, 3'd6, 16'h0004, rd, act, err); chk("R6 set action", act, 6);
        acc(0, 1, 3'd6, 0, rd, act, err); chk("R6 reset status", rd, 16'h0080);
        chk("R6 soft_rst", soft_rst, 1); chk("R6 st_req dropped", st_req, 0);
        chk("R6 irq cleared", intrq, 0);
        acc(1, 1, 3'd6, 16'h0000, rd, act, err); chk("R6 release action", act, 7);
        acc(0, 1, 3'd6, 0, rd, act, err); chk("R6 released status", rd, 16'h0040);
        acc(0, 0, 3'd1, 0, rd, act, err); chk("R6 error diag", rd, 16'h0001);
        acc(1, 1, 3'd6, 16'h0000, rd, act, err); chk("R6 idle clear action", act, 0);

        // R13 unassigned control offsets
        acc(1, 1, 3'd3, 16'h0006, rd, act, err);
        chk("R13 write flagged", err, 1); chk("R13 no action", act, 0);
        chk("R13 no reset", soft_rst, 0);
        acc(0, 1, 3'd6, 0, rd, act, err); chk("R13 status untouched", rd, 16'h0040);
        acc(0, 1, 3'd0, 0, rd, act, err);
        chk("R13 read zero", rd, 16'h0000); chk("R13 read flagged", err, 1);
        acc(0, 1, 3'd6, 0, rd, act, err); chk("R13 flag is a pulse", err, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule